// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Blank/Convert Line

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. It owns the trial register and the sequencing of a binary search. It drives a trial code to an external DAC, reads back one comparator bit, and settles one result bit per bit-cycle, starting at the most significant bit. The DAC, the reference and the comparator sit outside the block.

A single level-sensitive control line does two jobs. While the line is low, a conversion runs and the result is then presented. While it is high, the outputs are blanked and the block waits. The result bus has an enable that stands in for three-state pins, so that several converters can share one bus. Completion is signalled on an active-low ready line that is suited to a wired-OR status net.

A range input selects unipolar or bipolar operation. The block captures this input when a conversion starts and passes it to the DAC as an offset enable. In bipolar mode the code is offset binary, so code 0x200 stands for zero volts.

Top module: `sarConverter`

## Requirements
- R1: After reset, readyN is 1, dataOutEn is 0 and dataOut is 0.
- R2: A rising clock edge that samples ctlLine low while the block is blanked starts a conversion. After that edge, dacCode is 0x200, which sets only the MSB trial bit.
- R3: At the end of each bit-cycle, the bit under trial is kept if cmpGe is 1 and cleared if it is 0, and the next lower bit is then set. After 10 decisions the result equals the largest code whose DAC level does not exceed the input, so codes 0x000 and 0x3FF are both reachable.
- R4: One bit-cycle is CYCLES_PER_BIT = CONV_NS / (WIDTH * CLK_NS) clocks, which is 4 clocks at the defaults. readyN falls exactly WIDTH * CYCLES_PER_BIT clock edges after the edge that started the conversion.
- R5: While a conversion runs, readyN stays 1, dataOutEn stays 0 and dataOut reads 0.
- R6: When the last bit is decided, readyN goes to 0, dataOutEn goes to 1 and dataOut shows the result. These hold unchanged for as long as ctlLine stays low, whatever cmpGe does.
- R7: A clock edge that samples ctlLine high after completion blanks the outputs: readyN becomes 1, dataOutEn becomes 0 and dataOut becomes 0. The next low level starts a fresh conversion.
- R8: A clock edge that samples ctlLine high during a conversion aborts it. readyN stays 1, the outputs stay disabled, and a later conversion gives a correct result.
- R9: The edge that starts a conversion captures bipolarSel, and this value appears on dacOffsetEn. Changes to bipolarSel during the conversion have no effect. With bipolarSel at 1, an input of 0 V converts to 0x200, the most negative input converts to 0x000, and the most positive input converts to 0x3FF.
- R10: readyN is 0 exactly when dataOutEn is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlLine | input | 1 | Low: convert, then present data. High: blank and wait |
| bipolarSel | input | 1 | 1 selects the bipolar range, captured at conversion start |
| cmpGe | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| dacCode | output | 10 | Trial code for the external DAC |
| dacOffsetEn | output | 1 | Captured range mode that shifts the DAC by half scale |
| dataOut | output | 10 | Conversion result, reads 0 when disabled |
| dataOutEn | output | 1 | Output enable, stands in for three-state drive |
| readyN | output | 1 | Active-low data ready |

## Verification
The bench targets both ends of the code range. A design that set the wrong bit first, or that never cleared a rejected bit, would fail to reach 0x000 or 0x3FF. It also counts the edges to completion, so an off-by-one bit-cycle counter shows up as a wrong conversion time. Aborting mid-conversion and flipping the range input mid-conversion test two cases: a design that let ready fall after an abort, or that resampled the mode, would show a stale result or a code offset by half scale. Holding the line low while the comparator moves catches a result register that keeps tracking the search after completion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,
    ST_CONV  = 2'd1,
    ST_DONE  = 2'd2
  } sarState_t;

  typedef struct packed {
    logic start;   // begin a conversion: load MSB trial, capture mode
    logic decide;  // settle the bit under trial
    logic blank;   // leave conversion or readout, park the DAC
  } sarStrobe_t;

endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sar_pkg::*;
#(
  parameter int CPB = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlLine,
  input  logic       lastBit,
  output sarStrobe_t strb,
  output logic       busy,
  output logic       readyN,
  output logic       outEn
);

  localparam int TW = (CPB > 1) ? $clog2(CPB) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(CPB - 1);

  sarState_t st, stNext;
  logic [TW-1:0] tick;

  always_comb begin
    strb   = '0;
    stNext = st;
    case (st)
      ST_BLANK: begin
        if (!ctlLine) begin
          strb.start = 1'b1;
          stNext     = ST_CONV;
        end
      end
      ST_CONV: begin
        if (ctlLine) begin
          strb.blank = 1'b1;
          stNext     = ST_BLANK;
        end else if (tick == TICK_LAST) begin
          strb.decide = 1'b1;
          if (lastBit) stNext = ST_DONE;
        end
      end
      ST_DONE: begin
        if (ctlLine) begin
          strb.blank = 1'b1;
          stNext     = ST_BLANK;
        end
      end
      default: stNext = ST_BLANK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_BLANK;
      tick <= '0;
    end else begin
      st <= stNext;
      if (strb.start || st != ST_CONV || tick == TICK_LAST) tick <= '0;
      else tick <= tick + 1'b1;
    end
  end

  assign busy   = (st == ST_CONV);
  assign outEn  = (st == ST_DONE);
  assign readyN = (st != ST_DONE);

endmodule

// File: rtl/sarData.sv
module sarData
  import sar_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strb,
  input  logic             cmpGe,
  input  logic             bipolarSel,
  input  logic             outEn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] dataOut,
  output logic             dacOffsetEn,
  output logic             lastBit
);

  localparam int IW = $clog2(WIDTH + 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial, nextTrial, result;
  logic [IW-1:0]    idx;
  logic             modeReg;

  // Per-bit next value: the bit under trial takes the comparator,
  // the bit just below it is raised as the next trial, others hold.
  for (genvar g = 0; g < WIDTH; g++) begin : gBit
    assign nextTrial[g] = (idx == IW'(g))     ? cmpGe :
                          (idx == IW'(g + 1)) ? 1'b1  : trial[g];
  end

  assign lastBit = (idx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial   <= '0;
      idx     <= '0;
      result  <= '0;
      modeReg <= 1'b0;
    end else if (strb.start) begin
      trial   <= MSB_ONLY;
      idx     <= IW'(WIDTH - 1);
      modeReg <= bipolarSel;
    end else if (strb.decide) begin
      trial <= nextTrial;
      if (!lastBit) idx <= idx - 1'b1;
      else result <= nextTrial;
    end else if (strb.blank) begin
      trial <= '0;
    end
  end

  assign dacCode     = trial;
  assign dacOffsetEn = modeReg;
  assign dataOut     = outEn ? result : '0;

endmodule

// File: rtl/sarConverter.sv
module sarConverter
  import sar_pkg::*;
#(
  parameter int WIDTH   = 10,
  parameter int CLK_NS  = 625,
  parameter int CONV_NS = 25000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlLine,
  input  logic             bipolarSel,
  input  logic             cmpGe,
  output logic [WIDTH-1:0] dacCode,
  output logic             dacOffsetEn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOutEn,
  output logic             readyN
);

  localparam int CPB_RAW = CONV_NS / (WIDTH * CLK_NS);
  localparam int CPB     = (CPB_RAW < 1) ? 1 : CPB_RAW;

  sarStrobe_t strb;
  logic       lastBit;
  logic       convBusy;

  sarCtrl #(.CPB(CPB)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ctlLine(ctlLine),
    .lastBit(lastBit),
    .strb   (strb),
    .busy   (convBusy),
    .readyN (readyN),
    .outEn  (dataOutEn)
  );

  sarData #(.WIDTH(WIDTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmpGe      (cmpGe),
    .bipolarSel (bipolarSel),
    .outEn      (dataOutEn),
    .dacCode    (dacCode),
    .dataOut    (dataOut),
    .dacOffsetEn(dacOffsetEn),
    .lastBit    (lastBit)
  );

endmodule

// File: rtl/sarConverterChk.sv
module sarConverterChk #(
  parameter int WIDTH = 10,
  parameter int CPB   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlLine,
  input logic             readyN,
  input logic             dataOutEn,
  input logic [WIDTH-1:0] dataOut,
  input logic [WIDTH-1:0] dacCode,
  input logic             dacOffsetEn,
  input logic             busy,
  input logic             startStb
);

  int unsigned edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= 0;
    else if (startStb) edgeCnt <= 1;
    else if (busy) edgeCnt <= edgeCnt + 1;
  end

  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (dacCode == {1'b1, {(WIDTH-1){1'b0}}}));

  // R4
  conv_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> (edgeCnt == WIDTH * CPB + 1));

  // R5
  blanked_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == '0));

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyN && !ctlLine) |=> (!readyN && $stable(dataOut)));

  // R7
  blank_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlLine |=> (readyN && !dataOutEn));

  // R9
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startStb) |=> $stable(dacOffsetEn));

  // R10
  ready_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyN == !dataOutEn));

endmodule

bind sarConverter sarConverterChk #(.WIDTH(WIDTH), .CPB(CPB)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .ctlLine    (ctlLine),
  .readyN     (readyN),
  .dataOutEn  (dataOutEn),
  .dataOut    (dataOut),
  .dacCode    (dacCode),
  .dacOffsetEn(dacOffsetEn),
  .busy       (convBusy),
  .startStb   (strb.start)
);

// File: tb/sarConverter_bench.sv
module sarConverter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 10;
  localparam int CPB = 4;     // 25000 / (10 * 625)
  localparam int NV  = 10;
  // {bipolar, analog level in LSB steps, expected code}
  localparam int VEC [0:NV-1][0:2] = '{
    '{0,    0, 'h000}, '{0, 1023, 'h3FF}, '{0,    1, 'h001},
    '{0,  512, 'h200}, '{0,  341, 'h155}, '{0,  682, 'h2AA},
    '{1,    0, 'h200}, '{1, -512, 'h000}, '{1,  511, 'h3FF},
    '{1,   -1, 'h1FF}
  };

  logic clk = 0, rstN = 0, ctlLine = 1, bipolarSel = 0;
  logic cmpGe, dacOffsetEn, dataOutEn, readyN;
  logic [W-1:0] dacCode, dataOut;
  int ain = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ideal DAC plus comparator
  int dacLevel;
  assign dacLevel = dacOffsetEn ? (int'(dacCode) - 512) : int'(dacCode);
  assign cmpGe = (ain >= dacLevel);

  sarConverter u_sarConverter (
    .clk(clk), .rstN(rstN), .ctlLine(ctlLine), .bipolarSel(bipolarSel),
    .cmpGe(cmpGe), .dacCode(dacCode), .dacOffsetEn(dacOffsetEn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .readyN(readyN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge, wait for completion, check timing and blanking.
  task automatic convert(input int expCode);
    int n = 0;
    bit leak = 0;
    @(negedge clk) ctlLine = 0;
    @(negedge clk) n = 1;
    check(dacCode == 10'h200, "R2 msb trial", dacCode, 'h200);
    while (readyN && n < 1000) begin
      if (dataOutEn || dataOut != 0) leak = 1;
      @(negedge clk) n++;
    end
    check(!leak, "R5 outputs off while converting", leak, 0);
    check(n == W*CPB + 1, "R4 conversion edges", n - 1, W*CPB);
    check(dataOutEn && dataOut == W'(expCode), "R3 R6 result", dataOut, expCode);
  endtask

  task automatic blankOut();
    @(negedge clk) ctlLine = 1;
    @(negedge clk);
    check(readyN && !dataOutEn && dataOut == 0, "R7 blank", {readyN, dataOutEn}, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(readyN && !dataOutEn && dataOut == 0, "R1 reset", {readyN, dataOutEn}, 2);
    rstN = 1;
    @(negedge clk);

    // Vector table: R3 across unipolar and bipolar codes, R9 range
    for (int i = 0; i < NV; i++) begin
      bipolarSel = VEC[i][0][0];
      ain = VEC[i][1];
      convert(VEC[i][2]);
      check(!readyN == dataOutEn, "R10 ready matches enable", readyN, !dataOutEn);
      blankOut();
    end

    // R6: hold while line low, comparator moving
    bipolarSel = 0; ain = 700;
    convert(700);
    ain = 5;
    repeat (20) @(negedge clk);
    check(!readyN && dataOut == 10'd700, "R6 hold", dataOut, 700);
    blankOut();

    // R8: abort mid-conversion, then a clean conversion
    ain = 900;
    @(negedge clk) ctlLine = 0;
    repeat (7) @(negedge clk);
    ctlLine = 1;
    @(negedge clk);
    check(readyN && !dataOutEn, "R8 abort blanks", {readyN, dataOutEn}, 2);
    repeat (50) @(negedge clk);
    check(readyN && !dataOutEn && dataOut == 0, "R8 stays blanked", dataOut, 0);
    ain = 300;
    convert(300);
    blankOut();

    // R9: mode captured at start, later change ignored
    bipolarSel = 1; ain = 0;
    @(negedge clk) ctlLine = 0;
    repeat (3) @(negedge clk);
    bipolarSel = 0;
    while (readyN) @(negedge clk);
    check(dataOut == 10'h200 && dacOffsetEn, "R9 mode latched", dataOut, 'h200);
    blankOut();

    // R7: fresh conversion after blanking uses new mode
    ain = 0;
    convert(0);
    check(!dacOffsetEn, "R9 R7 new mode at next start", dacOffsetEn, 0);
    blankOut();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule